// File: doc/BRIEF.md
# Fixed-Point to Single-Precision Float Converter

This block takes a signed binary number held as a sign flag and a magnitude split into an integer field and a fraction field, and returns the same value packed as a 32-bit IEEE 754 single-precision word. The binary point sits between the two fields. The leading one can fall in either field. The block finds it across the combined field, normalises the value to the form 1.f × 2^e, and packs the sign, the biased exponent and a truncated fraction.

The converter sits in a datapath that feeds fixed-point samples into a float unit. It accepts one value per clock when the input strobe is high. The packed result appears one cycle later together with an output strobe. The block does no rounding. A zero magnitude produces a signed zero. No other special value can arise from these inputs.

Top module: `fx2f_conv`

## Requirements
- R1: Output bit 31 equals the input sign: 0 for a positive value and 1 for a negative value.
- R2: The leading one is found across the 48-bit field {integer, fraction}. Bit 0 is the lowest fraction bit and bit 47 is the top integer bit. With the leading one at position p, output bits 30:23 hold p − 32 + 127 as an unsigned 8-bit number. So integer value 1 gives 127, integer bit 15 gives 142, the top fraction bit gives 126 and the lowest fraction bit gives 95.
- R3: Output bits 22:0 hold the 23 bits that directly follow the leading one, with the most significant of them in bit 22. The leading one itself is not stored.
- R4: When fewer than 23 bits follow the leading one, the unused low bits of the fraction are zero.
- R5: Bits more than 23 places below the leading one are discarded with no rounding, and the exponent never increments because of them.
- R6: An all-zero magnitude gives output bits 30:0 all zero, with the sign still taken from the input.
- R7: The output strobe is high exactly one cycle after the input strobe was high. The word shown in that cycle is the conversion of the inputs captured with that strobe.
- R8: While the input strobe is low, the output word keeps its last value, whatever the data inputs do.
- R9: After reset the output strobe is 0 and the output word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input strobe: capture and convert this cycle |
| inSign | input | 1 | Sign of the value (1 = negative) |
| inInt | input | 16 | Integer part of the magnitude |
| inFrac | input | 32 | Fraction part of the magnitude |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| outWord | output | 32 | Packed single-precision result |

## Verification
The bench places the leading one at the very top of the integer field, just above and just below the binary point, and at the lowest fraction bit. A converter that counts the exponent from the wrong origin, or that misses one end of the combined field, gives an exponent off by a constant or a zero word for those values. Inputs of all ones and a value with a set bit exactly 24 places below the leading one expose any rounding, because a rounding design would bump the exponent or the fraction LSB. Short mantissas check the zero padding. Signed zeros, held outputs while the strobe is low, and the one-cycle strobe timing catch a design that drops the sign, updates on idle cycles, or shows the result a cycle early or late.

// File: rtl/fx2f_pkg.sv
package fx2f_pkg;
  localparam int INT_W = 16;
  localparam int FRAC_W = 32;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int BIAS = 127;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;
  } ctrl_t;
endpackage

// File: rtl/fx2f_lead_one.sv
module fx2f_lead_one #(
  parameter int W = 48,
  localparam int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos,
  output logic          found
);
  always_comb begin
    pos = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        pos = PW'(i);
        found = 1'b1;
      end
    end
  end

  // R2: the reported position carries a one
  always_comb begin
    if (found) begin
      lead_bit_chk: assert (vec[pos]);
    end
  end
endmodule

// File: rtl/fx2f_ctrl.sv
module fx2f_ctrl
  import fx2f_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  inValid,
  output ctrl_t strobe,
  output logic  outValid
);
  always_comb strobe.loadEn = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else outValid <= inValid;
  end
endmodule

// File: rtl/fx2f_datapath.sv
module fx2f_datapath
  import fx2f_pkg::*;
#(
  parameter int IW = INT_W,
  parameter int FW = FRAC_W,
  parameter int EW = EXP_W,
  parameter int MW = MAN_W,
  parameter int BI = BIAS,
  localparam int MAG_W = IW + FW,
  localparam int PW = $clog2(MAG_W),
  localparam int WORD_W = 1 + EW + MW,
  localparam int EXP_OFS = BI - FW
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             strobe,
  input  logic              sign,
  input  logic [IW-1:0]     intPart,
  input  logic [FW-1:0]     fracPart,
  output logic [WORD_W-1:0] outWord
);
  logic [MAG_W-1:0] mag;
  logic [PW-1:0]    leadPos;
  logic             nonZero;
  logic [MAG_W-1:0] normMag;
  logic [MW-1:0]    manBits;
  logic [EW-1:0]    expBits;

  assign mag = {intPart, fracPart};

  fx2f_lead_one #(.W(MAG_W)) u_lead (
    .vec(mag),
    .pos(leadPos),
    .found(nonZero)
  );

  // place the leading one at the top bit
  always_comb normMag = mag << (PW'(MAG_W - 1) - leadPos);

  generate
    if (MAG_W - 1 >= MW) begin : g_trunc
      assign manBits = normMag[MAG_W-2 -: MW];
    end else begin : g_pad
      assign manBits = {normMag[MAG_W-2:0], {(MW - MAG_W + 1){1'b0}}};
    end
  endgenerate

  always_comb expBits = nonZero ? (EW'(leadPos) + EW'(EXP_OFS)) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outWord <= '0;
    else if (strobe.loadEn) outWord <= {sign, expBits, nonZero ? manBits : {MW{1'b0}}};
  end

  // R1
  sign_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEn |=> outWord[WORD_W-1] == $past(sign));
  // R6
  zero_mag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEn && mag == '0) |=> outWord[WORD_W-2:0] == '0);
  // R2
  exp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEn && mag != '0) |=>
      (outWord[WORD_W-2 -: EW] >= EW'(EXP_OFS)) &&
      (outWord[WORD_W-2 -: EW] <= EW'(EXP_OFS + MAG_W - 1)));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadEn |=> $stable(outWord));
endmodule

// File: rtl/fx2f_conv.sv
module fx2f_conv
  import fx2f_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSign,
  input  logic [INT_W-1:0]  inInt,
  input  logic [FRAC_W-1:0] inFrac,
  output logic              outValid,
  output logic [31:0]       outWord
);
  ctrl_t strobe;

  fx2f_ctrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .inValid(inValid),
    .strobe(strobe),
    .outValid(outValid)
  );

  fx2f_datapath u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .sign(inSign),
    .intPart(inInt),
    .fracPart(inFrac),
    .outWord(outWord)
  );

  // R7
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: tb/fx2f_conv_bench.sv
module fx2f_conv_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inSign = 1'b0;
  logic [15:0] inInt = '0;
  logic [31:0] inFrac = '0;
  logic outValid;
  logic [31:0] outWord;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fx2f_conv u_fx2f_conv (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSign(inSign),
    .inInt(inInt), .inFrac(inFrac), .outValid(outValid), .outWord(outWord)
  );

  // {sign, integer, fraction, expected word}
  localparam int NV = 14;
  localparam logic [80:0] VECS [NV] = '{
    {1'b0, 16'h0001, 32'h00000000, 32'h3F800000},  // R2 exp 127
    {1'b1, 16'h8000, 32'h00000000, 32'hC7000000},  // R2 R1 top bit
    {1'b0, 16'h0000, 32'h80000000, 32'h3F000000},  // R2 below point
    {1'b0, 16'h0000, 32'h00000001, 32'h2F800000},  // R2 lowest bit
    {1'b0, 16'h0003, 32'h40000000, 32'h40500000},  // R3 3.25
    {1'b0, 16'h0000, 32'hFFFFFFFF, 32'h3F7FFFFF},  // R5 no round-up
    {1'b1, 16'hFFFF, 32'hFFFFFFFF, 32'hC77FFFFF},  // R5 all ones
    {1'b0, 16'h0001, 32'h00000100, 32'h3F800000},  // R5 bit 24 below lost
    {1'b0, 16'h0001, 32'h00000200, 32'h3F800001},  // R3 fraction LSB
    {1'b1, 16'h0000, 32'h00000000, 32'h80000000},  // R6 negative zero
    {1'b0, 16'h0000, 32'h00000000, 32'h00000000},  // R6 positive zero
    {1'b0, 16'h0005, 32'h00000000, 32'h40A00000},  // R4 padding
    {1'b0, 16'h0000, 32'h00000003, 32'h30400000},  // R4 short tail
    {1'b0, 16'h1234, 32'h56789ABC, 32'h4591A2B3}   // R3 mixed
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic convert(input logic s, input logic [15:0] i, input logic [31:0] f);
    @(negedge clk);
    inSign = s; inInt = i; inFrac = f; inValid = 1'b1;
    @(posedge clk);
    #1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk);
    #1;
    check("R9 outValid", {31'b0, outValid}, 32'h0);
    check("R9 outWord", outWord, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {inSign, inInt, inFrac} = VECS[k][80:32];
      inValid = 1'b1;
      @(posedge clk);
      #1;
      check("R7 strobe", {31'b0, outValid}, 32'h1);
      check("R1-R6 vector", outWord, VECS[k][31:0]);
    end
    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk);
    #1;
    check("R7 strobe drop", {31'b0, outValid}, 32'h0);

    // R8: idle inputs change, word holds
    convert(1'b0, 16'h0001, 32'h0);
    held = outWord;
    check("R8 base", held, 32'h3F800000);
    @(negedge clk);
    inSign = 1'b1; inInt = 16'hABCD; inFrac = 32'h12345678;
    repeat (3) @(posedge clk);
    #1;
    check("R8 hold", outWord, held);
    check("R8 no strobe", {31'b0, outValid}, 32'h0);

    // R7: result not visible before the capturing edge
    @(negedge clk);
    inSign = 1'b0; inInt = 16'h8000; inFrac = 32'h0; inValid = 1'b1;
    #1;
    check("R7 early", outWord, held);
    @(posedge clk);
    #1;
    check("R7 late", outWord, 32'h47000000);
    @(negedge clk);
    inValid = 1'b0;

    // R9: reset mid-run clears outputs
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R9 rerun word", outWord, 32'h0);
    check("R9 rerun strobe", {31'b0, outValid}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule